// File: doc/BRIEF.md
# Multi-Mode Complex Waveform Generator

This block synthesizes complex baseband test signals for a receiver test loop. It keeps a 32-bit phase accumulator. The top 12 bits of that phase select an entry from a sine/cosine table that the block computes from a quarter wave. Each clock cycle yields one in-phase sample and one quadrature sample, together with a valid flag. The stream goes toward a DAC path.

Three modes share the synthesizer core. Tone mode runs a continuous, ungated carrier. Gated mode switches a fixed-frequency tone on for a programmable number of samples in each repetition period. Chirp mode also gates by pulse, but a second accumulator raises the phase increment by a fixed step on every sample, so the frequency sweeps linearly across each pulse.

In the two pulsed modes, settings are sampled only on the first sample of a pulse. This means a pulse is never emitted with a mix of old and new settings. Dropping enable clears every accumulator and counter, and the next run starts cleanly.

Top module: `waveform_gen`

## Requirements
- R1: After reset, out_valid is 0 and out_i and out_q are 0. The same holds from the third rising edge at which enable is sampled low. A later run restarts at pulse position 0, with the phase and the chirp increment cleared.
- R2: Sample n of a run appears on the outputs right after rising edge n+2. Sample 0 belongs to the first edge at which enable is sampled high. out_valid stays 1 on every cycle while enable stays high, including cycles outside a pulse.
- R3: Let p be phase bits [31:20]. Then out_i = round(32767·cos(2πp/4096)) and out_q = round(32767·sin(2πp/4096)). Rounding is half away from zero, and both outputs are 16-bit two's complement.
- R4: Mode code 0 is tone mode, and code 3 behaves the same. Every sample is active. The phase of sample 0 is 0. The phase of sample n+1 is the phase of sample n plus the freq_word sampled at sample n's edge, modulo 2^32, so a new word takes effect on the very next sample.
- R5: In mode 1 (chirp) and mode 2 (gated), a pulse position counts 0 to pulse_period−1 and then wraps; a period of 0 acts as 1. A sample is active only when its position is below pulse_len. Inactive samples have out_i = out_q = 0 while out_valid stays 1.
- R6: In gated mode, the phase at position k equals k·freq_word modulo 2^32, so every pulse starts at phase 0.
- R7: In chirp mode, the increment at position 0 is freq_word and grows by chirp_step on each later sample. The phase at position k is therefore k·freq_word + chirp_step·k(k−1)/2 modulo 2^32.
- R8: In modes 1 and 2, mode, freq_word, chirp_step, pulse_len and pulse_period are taken only at the edge of a position-0 sample. A value presented at that edge applies to the pulse it starts. A change made at any other edge is ignored until the next position 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run enable; low clears accumulators and counters |
| mode | input | 2 | 0 tone, 1 chirp, 2 gated, 3 tone |
| freq_word | input | 32 | Tone frequency or chirp start increment |
| chirp_step | input | 32 | Per-sample increment growth in chirp mode |
| pulse_len | input | 16 | Active samples per pulse |
| pulse_period | input | 16 | Samples per repetition period |
| out_i | output | 16 | In-phase sample |
| out_q | output | 16 | Quadrature sample |
| out_valid | output | 1 | Sample strobe |

## Verification
Two events can land on the same edge: the wrap of the pulse position back to 0, and a settings change on the inputs. That edge decides which pulse the change belongs to. The bench stages a chirp-step change so that it is captured exactly at a position-0 edge, and expects the new step from that pulse onward. Other runs change the width, frequency or mode a few samples into a pulse, and expect the old values to persist until the following boundary. Each output sample is compared against phases computed in closed form from the position inside its pulse.

// File: rtl/wgen_pkg.sv
package wgen_pkg;
  typedef enum logic [1:0] {
    WG_TONE  = 2'd0,
    WG_CHIRP = 2'd1,
    WG_GATED = 2'd2,
    WG_SPARE = 2'd3
  } wg_mode_e;
endpackage

// File: rtl/wgen_pulse_timer.sv
module wgen_pulse_timer
  import wgen_pkg::*;
#(
  parameter int PHASE_W = 32,
  parameter int CNT_W   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               enable,
  input  logic [1:0]         mode_i,
  input  logic [PHASE_W-1:0] freq_i,
  input  logic [PHASE_W-1:0] rate_i,
  input  logic [CNT_W-1:0]   width_i,
  input  logic [CNT_W-1:0]   period_i,
  output logic               first_o,
  output logic               gate_o,
  output logic               chirp_o,
  output logic [PHASE_W-1:0] freq_o,
  output logic [PHASE_W-1:0] rate_o
);

  logic [CNT_W-1:0]   pos_q;
  logic [CNT_W-1:0]   width_q, period_q;
  logic [PHASE_W-1:0] freq_q, rate_q;
  wg_mode_e           mode_q;

  logic               at_start, tone;
  wg_mode_e           mode_e;
  logic [CNT_W-1:0]   width_e, period_e;
  logic [CNT_W:0]     pos_inc;

  // settings seen by this sample: live at a boundary, frozen inside a pulse
  always_comb begin
    at_start = (pos_q == '0);
    mode_e   = at_start ? wg_mode_e'(mode_i) : mode_q;
    width_e  = at_start ? width_i  : width_q;
    period_e = at_start ? period_i : period_q;
    freq_o   = at_start ? freq_i   : freq_q;
    rate_o   = at_start ? rate_i   : rate_q;
    tone     = !(mode_e == WG_CHIRP || mode_e == WG_GATED);
    pos_inc  = {1'b0, pos_q} + 1'b1;
    first_o  = at_start && !tone;
    gate_o   = tone || (pos_q < width_e);
    chirp_o  = (mode_e == WG_CHIRP);
  end

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      pos_q    <= '0;
      mode_q   <= WG_TONE;
      width_q  <= '0;
      period_q <= '0;
      freq_q   <= '0;
      rate_q   <= '0;
    end else begin
      if (at_start) begin
        mode_q   <= wg_mode_e'(mode_i);
        width_q  <= width_i;
        period_q <= period_i;
        freq_q   <= freq_i;
        rate_q   <= rate_i;
      end
      if (tone || pos_inc >= {1'b0, period_e})
        pos_q <= '0;
      else
        pos_q <= pos_inc[CNT_W-1:0];
    end
  end

  // R5
  pos_range_chk: assert property (@(posedge clk) disable iff (rst)
    (pos_q == '0) || (pos_q < period_q));

  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (enable && $past(enable) && pos_q != '0 && $past(pos_q) != '0) |->
    ($stable(freq_q) && $stable(rate_q) && $stable(width_q) &&
     $stable(period_q) && $stable(mode_q)));

endmodule

// File: rtl/wgen_dds_core.sv
module wgen_dds_core #(
  parameter int PHASE_W = 32,
  parameter int AW      = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               enable,
  input  logic               first_i,
  input  logic               gate_i,
  input  logic               chirp_i,
  input  logic [PHASE_W-1:0] freq_i,
  input  logic [PHASE_W-1:0] rate_i,
  output logic [AW-1:0]      phase_o,
  output logic               gate_o,
  output logic               vld_o
);

  logic [PHASE_W-1:0] acc_q, inc_q;
  logic [PHASE_W-1:0] ph_now, inc_now;

  always_comb begin
    ph_now = first_i ? '0 : acc_q;
    if (chirp_i && !first_i)
      inc_now = inc_q + rate_i;
    else
      inc_now = freq_i;
  end

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      acc_q   <= '0;
      inc_q   <= '0;
      phase_o <= '0;
      gate_o  <= 1'b0;
      vld_o   <= 1'b0;
    end else begin
      acc_q   <= ph_now + inc_now;
      inc_q   <= inc_now;
      phase_o <= ph_now[PHASE_W-1 -: AW];
      gate_o  <= gate_i;
      vld_o   <= 1'b1;
    end
  end

  // R1
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (acc_q == '0 && inc_q == '0 && !vld_o));

  // R6
  phase_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (enable && first_i) |=> (phase_o == '0));

endmodule

// File: rtl/wgen_sincos_lut.sv
module wgen_sincos_lut #(
  parameter int AW = 12,
  parameter int SW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [AW-1:0]        phase_i,
  input  logic                 gate_i,
  input  logic                 vld_i,
  output logic signed [SW-1:0] i_o,
  output logic signed [SW-1:0] q_o,
  output logic                 vld_o
);

  localparam int  QW    = AW - 2;
  localparam int  QN    = 1 << QW;
  localparam int  AMP   = (1 << (SW - 1)) - 1;
  localparam real TWOPI = 6.283185307179586;

  logic [SW-1:0] rom [0:QN];

  initial begin
    real a;
    for (int k = 0; k <= QN; k++) begin
      a = real'(AMP) * $sin(TWOPI * real'(k) / real'(4 * QN));
      rom[k] = SW'($rtoi(a + 0.5));
    end
  end

  function automatic logic [QW:0] fold(input logic [AW-1:0] a);
    logic [QW:0] k;
    k = {1'b0, a[QW-1:0]};
    return a[AW-2] ? ((QW+1)'(QN) - k) : k;
  endfunction

  logic [AW-1:0] pc;
  logic [QW:0]   s_idx, c_idx;

  always_comb begin
    pc    = phase_i + AW'(QN);
    s_idx = fold(phase_i);
    c_idx = fold(pc);
  end

  // stage 1: table reads, no reset so a block ROM can be used
  logic [SW-1:0] s_mag, c_mag;
  always_ff @(posedge clk) begin
    s_mag <= rom[s_idx];
    c_mag <= rom[c_idx];
  end

  logic s_neg1, c_neg1, gate1, vld1;
  always_ff @(posedge clk) begin
    if (rst) begin
      s_neg1 <= 1'b0;
      c_neg1 <= 1'b0;
      gate1  <= 1'b0;
      vld1   <= 1'b0;
    end else begin
      s_neg1 <= phase_i[AW-1];
      c_neg1 <= pc[AW-1];
      gate1  <= gate_i && vld_i;
      vld1   <= vld_i;
    end
  end

  // stage 2: sign and gating into the output registers
  logic signed [SW-1:0] s_val, c_val;
  always_comb begin
    s_val = $signed(s_mag);
    c_val = $signed(c_mag);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      i_o   <= '0;
      q_o   <= '0;
      vld_o <= 1'b0;
    end else begin
      i_o   <= gate1 ? (c_neg1 ? -c_val : c_val) : '0;
      q_o   <= gate1 ? (s_neg1 ? -s_val : s_val) : '0;
      vld_o <= vld1;
    end
  end

  // R3
  amp_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (i_o <= SW'(AMP)) && (i_o >= -SW'(AMP)) &&
    (q_o <= SW'(AMP)) && (q_o >= -SW'(AMP)));

endmodule

// File: rtl/waveform_gen.sv
module waveform_gen #(
  parameter int PHASE_W = 32,
  parameter int LUT_AW  = 12,
  parameter int SAMP_W  = 16,
  parameter int CNT_W   = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     enable,
  input  logic [1:0]               mode,
  input  logic [PHASE_W-1:0]       freq_word,
  input  logic [PHASE_W-1:0]       chirp_step,
  input  logic [CNT_W-1:0]         pulse_len,
  input  logic [CNT_W-1:0]         pulse_period,
  output logic signed [SAMP_W-1:0] out_i,
  output logic signed [SAMP_W-1:0] out_q,
  output logic                     out_valid
);

  logic               tm_first, tm_gate, tm_chirp;
  logic [PHASE_W-1:0] tm_freq, tm_rate;
  logic [LUT_AW-1:0]  dds_phase;
  logic               dds_gate, dds_vld;

  wgen_pulse_timer #(.PHASE_W(PHASE_W), .CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .enable(enable),
    .mode_i(mode), .freq_i(freq_word), .rate_i(chirp_step),
    .width_i(pulse_len), .period_i(pulse_period),
    .first_o(tm_first), .gate_o(tm_gate), .chirp_o(tm_chirp),
    .freq_o(tm_freq), .rate_o(tm_rate)
  );

  wgen_dds_core #(.PHASE_W(PHASE_W), .AW(LUT_AW)) u_dds (
    .clk(clk), .rst(rst), .enable(enable),
    .first_i(tm_first), .gate_i(tm_gate), .chirp_i(tm_chirp),
    .freq_i(tm_freq), .rate_i(tm_rate),
    .phase_o(dds_phase), .gate_o(dds_gate), .vld_o(dds_vld)
  );

  wgen_sincos_lut #(.AW(LUT_AW), .SW(SAMP_W)) u_lut (
    .clk(clk), .rst(rst),
    .phase_i(dds_phase), .gate_i(dds_gate), .vld_i(dds_vld),
    .i_o(out_i), .q_o(out_q), .vld_o(out_valid)
  );

  // R2
  valid_run_chk: assert property (@(posedge clk) disable iff (rst)
    (enable && $past(enable) && $past(enable, 2) && $past(enable, 3)) |-> out_valid);

  // R5
  gap_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(dds_vld, 2) && !$past(dds_gate, 2)) |-> (out_i == '0 && out_q == '0));

endmodule

// File: tb/sim_waveform_gen.sv
module sim_waveform_gen;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               enable = 1'b0;
  logic [1:0]         mode = 2'd0;
  logic [31:0]        freq_word = '0;
  logic [31:0]        chirp_step = '0;
  logic [15:0]        pulse_len = '0;
  logic [15:0]        pulse_period = '0;
  logic signed [15:0] out_i, out_q;
  logic               out_valid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  waveform_gen u0 (
    .clk(clk), .rst(rst), .enable(enable), .mode(mode),
    .freq_word(freq_word), .chirp_step(chirp_step),
    .pulse_len(pulse_len), .pulse_period(pulse_period),
    .out_i(out_i), .out_q(out_q), .out_valid(out_valid)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int expect_val(input logic [31:0] ph, input bit cosine);
    real x, v;
    x = 6.283185307179586 * real'(int'(ph[31:20])) / 4096.0;
    v = 32767.0 * (cosine ? $cos(x) : $sin(x));
    return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
  endfunction

  task automatic check_sample(input string tag, input bit act, input logic [31:0] ph);
    check(tag, "valid", int'(out_valid), 1);
    check(tag, "I", int'(out_i), act ? expect_val(ph, 1'b1) : 0);
    check(tag, "Q", int'(out_q), act ? expect_val(ph, 1'b0) : 0);
  endtask

  task automatic apply(input int m, input logic [31:0] f, input logic [31:0] r,
                       input int w, input int p);
    mode = 2'(m); freq_word = f; chirp_step = r;
    pulse_len = 16'(w); pulse_period = 16'(p);
  endtask

  task automatic stop_and_check(input string tag);
    @(negedge clk); enable = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(tag, "valid after stop", int'(out_valid), 0);
    check(tag, "I after stop", int'(out_i), 0);
    check(tag, "Q after stop", int'(out_q), 0);
  endtask

  // tone run, frequency word swapped after sample chg (captured at sample chg+3)
  task automatic run_tone(input string tag, input logic [31:0] f1, input logic [31:0] f2,
                          input int chg, input int nsamp);
    logic [31:0] ph;
    int eff;
    eff = (chg < 0) ? nsamp + 1 : chg + 3;
    apply(0, f1, 32'h0, 0, 0);
    @(negedge clk); enable = 1'b1;
    repeat (3) @(posedge clk);
    ph = '0;
    for (int n = 0; n < nsamp; n++) begin
      @(negedge clk);
      check_sample(tag, 1'b1, ph);
      if (n == chg) freq_word = f2;
      ph = ph + ((n >= eff) ? f2 : f1);
    end
    stop_and_check("R1");
  endtask

  // pulsed run; second setting applied after sample chg, active from next boundary
  task automatic run_gated(input string tag,
                           input int m1, input logic [31:0] f1, input logic [31:0] r1,
                           input int w1, input int p1, input int chg,
                           input int m2, input logic [31:0] f2, input logic [31:0] r2,
                           input int w2, input int p2, input int nsamp);
    int pe1, pe2, eff, pos, m, w;
    logic [31:0] f, r, ph, k;
    bit act;
    pe1 = (p1 == 0) ? 1 : p1;
    pe2 = (p2 == 0) ? 1 : p2;
    eff = (chg < 0) ? nsamp + 1 : ((chg + 3 + pe1 - 1) / pe1) * pe1;
    apply(m1, f1, r1, w1, p1);
    @(negedge clk); enable = 1'b1;
    repeat (3) @(posedge clk);
    for (int n = 0; n < nsamp; n++) begin
      @(negedge clk);
      if (n >= eff) begin
        pos = (n - eff) % pe2; m = m2; f = f2; r = r2; w = w2;
      end else begin
        pos = n % pe1; m = m1; f = f1; r = r1; w = w1;
      end
      act = (pos < w);
      k = 32'(pos);
      ph = k * f;
      if (m == 1) ph = ph + r * 32'((pos * (pos - 1)) / 2);
      check_sample(tag, act, ph);
      if (n == chg) apply(m2, f2, r2, w2, p2);
    end
    stop_and_check("R1");
  endtask

  task automatic test_reset();
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check("R1", "valid in reset state", int'(out_valid), 0);
    check("R1", "I in reset state", int'(out_i), 0);
    check("R1", "Q in reset state", int'(out_q), 0);
  endtask

  task automatic test_tone();
    run_tone("R4 R2", 32'h0123_4567, 32'h0A00_0F00, 10, 40);
  endtask

  task automatic test_gated_change();
    run_gated("R6 R8", 2, 32'h0200_0000, 32'h0, 5, 12, 11,
              2, 32'h0300_0000, 32'h0, 3, 12, 36);
  endtask

  task automatic test_chirp_boundary();
    run_gated("R7 R8", 1, 32'h0100_0000, 32'h0008_0000, 20, 25, 22,
              1, 32'h0100_0000, 32'h0004_0000, 20, 25, 40);
  endtask

  task automatic test_restart();
    run_gated("R1 R7", 1, 32'h0080_0000, 32'h0010_0000, 8, 10, -1,
              1, 32'h0, 32'h0, 0, 0, 14);
  endtask

  task automatic test_mode_switch();
    run_gated("R8", 2, 32'h0400_0000, 32'h0002_0000, 6, 10, 4,
              1, 32'h0400_0000, 32'h0002_0000, 6, 10, 30);
  endtask

  task automatic test_edges();
    run_gated("R5", 2, 32'h0111_0000, 32'h0, 4, 4, -1, 2, 32'h0, 32'h0, 0, 0, 12);
    run_gated("R5", 2, 32'h0111_0000, 32'h0, 0, 3, -1, 2, 32'h0, 32'h0, 0, 0, 9);
    run_gated("R5", 2, 32'h0111_0000, 32'h0, 1, 0, -1, 2, 32'h0, 32'h0, 0, 0, 6);
  endtask

  task automatic test_table_sweep();
    run_tone("R3", 32'h0010_0000, 32'h0010_0000, -1, 4100);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL R2 watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    test_reset();
    test_tone();
    test_gated_change();
    test_chirp_boundary();
    test_restart();
    test_mode_switch();
    test_edges();
    test_table_sweep();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule